// File: doc/BRIEF.md
# Accelerator Run-Phase Sequencer

This block is the cycle-level controller that decides, for a small accelerator core, what each clock cycle is spent on. After a start command it walks through a preparation phase that waits for the entropy source to be seeded, a single fetch-wait cycle, the execution phase where instructions are issued and retired, a one-cycle wind-down phase and, after a fault, a terminal lock phase. It drives the fetch enable, the retire and stall strobes, the clear for the random-request line, the step enable of the pseudo-random generator, and it keeps the retired-instruction counter.

In the execution phase the sequencer tracks whether an instruction word is on hand. Multi-cycle instructions keep the core stalled until their last cycle. An instruction flagged as needing a fetch bubble costs exactly one extra stall cycle. An instruction whose fetch failed, or that came from an invalidated instruction memory, is executed at once as a faulting instruction, whatever it was in the middle of. The run then ends in the lock phase. A halt seen on a retiring instruction ends the run normally.

Top module: `run_ctrl_seq`

## Requirements
- R1: After reset the phase is idle (phase code 0), the counter reads zero, and fetch enable, retire, stall, fault and generator step are low. Phase codes: 0 idle, 1 prepare, 2 fetch-wait, 3 execute, 4 wind-down, 5 lock.
- R2: A start pulse moves idle to prepare on the next edge. Start is ignored in every other phase.
- R3: The prepare phase lasts until seed-ready is seen high. While in it, the random-request clear and the counter clear are high and the generator step is low.
- R4: The fetch-wait phase lasts one cycle and then moves to execute. In it, fetch enable is low, the counter clear is high and the counter reads zero.
- R5: The generator step is high in fetch-wait, execute, wind-down and lock, and low in idle and prepare.
- R6: The first execute cycle has no instruction on hand. It is a stall cycle with fetch enable high, and the next cycle has an instruction on hand.
- R7: While the instruction on hand reports busy, each cycle is a stall with no retire and no fetch.
- R8: An instruction with valid bits and busy low retires that cycle. The counter then grows by one on the edge, holding at its all-ones value.
- R9: A retiring instruction with the fetch-bubble flag gets no fetch in its retire cycle. The next cycle is a stall with fetch enable high and no retire, and an instruction is on hand the cycle after.
- R10: A retiring instruction with halt high does not fetch. The next cycle is wind-down, then idle, and the counter keeps its value.
- R11: An on-hand instruction with fetch-ok low or instruction-memory-void high raises fault for that cycle, even while busy. It does not retire or count. The phase goes to wind-down and then to lock.
- R12: Lock holds until reset, ignores start, and signals stall every cycle.
- R13: The stall strobe is high exactly in the cycles where the phase is not idle and no instruction retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Run start command |
| seed_ready_i | input | 1 | Entropy source has delivered a seed |
| fetch_ok_i | input | 1 | Instruction on hand has valid bits |
| imem_void_i | input | 1 | Instruction memory invalidated, word treated as empty |
| busy_i | input | 1 | Instruction on hand needs more cycles |
| fstall_i | input | 1 | Instruction on hand requests a fetch bubble |
| halt_i | input | 1 | Halt pending for the instruction on hand |
| fetch_en_o | output | 1 | Fetch the next instruction this cycle |
| retire_o | output | 1 | Instruction retires this cycle |
| stall_o | output | 1 | Cycle is a stall cycle |
| fault_o | output | 1 | Faulting instruction executed this cycle |
| cnt_clr_o | output | 1 | Instruction counter held at zero |
| rnd_req_clr_o | output | 1 | Force the random-request line low |
| prng_step_o | output | 1 | Advance the pseudo-random generator |
| insn_cnt_o | output | CNT_W | Retired-instruction counter |
| phase_o | output | 3 | Current phase code |

## Verification
The bench checks that the fetch bubble costs exactly one cycle. A design that skipped the bubble would retire in the following cycle, and one that added two bubbles would still be stalling when the bench expects a retire. A fetch failure is injected while a multi-cycle instruction is busy. A design that let busy win would stall instead of faulting, and it would never reach lock. The counter is driven past its all-ones value, where a wrapping counter would read zero. The bench also checks that it is cleared on a second run, where a missing clear in prepare or fetch-wait would show the old count in fetch-wait.

// File: rtl/run_ctrl_pkg.sv
// Shared phase encoding for the run-phase sequencer.
// Assumes: codes are visible at the top port and fixed as listed.
package run_ctrl_pkg;
    localparam int PHASE_W = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE  = 3'd0,
        PH_PREP  = 3'd1,
        PH_FWAIT = 3'd2,
        PH_EXEC  = 3'd3,
        PH_WIND  = 3'd4,
        PH_LOCK  = 3'd5
    } phase_e;
endpackage

// File: rtl/run_phase_fsm.sv
// Phase register, instruction-on-hand flag and fault memory.
// Assumes: retire_i and bogus_i are decoded from this module's own state
// plus the instruction flags, and are never high together.
module run_phase_fsm
    import run_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   seed_ready_i,
    input  logic   retire_i,
    input  logic   bogus_i,
    input  logic   fstall_i,
    input  logic   halt_i,
    output phase_e phase_o,
    output logic   have_insn_o
);
    phase_e phase_q, phase_d;
    logic   have_q, have_d;
    logic   fault_q, fault_d;

    // Next phase selection.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:  if (start_i) phase_d = PH_PREP;
            PH_PREP:  if (seed_ready_i) phase_d = PH_FWAIT;
            PH_FWAIT: phase_d = PH_EXEC;
            PH_EXEC:  if (bogus_i || (retire_i && halt_i)) phase_d = PH_WIND;
            PH_WIND:  phase_d = fault_q ? PH_LOCK : PH_IDLE;
            PH_LOCK:  phase_d = PH_LOCK;
            default:  phase_d = PH_IDLE;
        endcase
    end

    // Instruction on hand: gained by a fetch, lost on a bubble, halt or fault.
    always_comb begin
        have_d = (phase_q == PH_EXEC) && !bogus_i &&
                 !(retire_i && (fstall_i || halt_i));
    end

    // Remember that the run ended in a fault until the phase returns to idle.
    always_comb begin
        fault_d = fault_q;
        if (phase_q == PH_IDLE) fault_d = 1'b0;
        else if (bogus_i)       fault_d = 1'b1;
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            have_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            have_q  <= have_d;
            fault_q <= fault_d;
        end
    end

    assign phase_o     = phase_q;
    assign have_insn_o = have_q;
endmodule

// File: rtl/run_issue_logic.sv
// Combinational decode of the per-cycle strobes from phase and flags.
// Assumes: flags describe the instruction on hand and are only meaningful
// when have_insn_i is high.
module run_issue_logic
    import run_ctrl_pkg::*;
(
    input  phase_e phase_i,
    input  logic   have_insn_i,
    input  logic   fetch_ok_i,
    input  logic   imem_void_i,
    input  logic   busy_i,
    input  logic   fstall_i,
    input  logic   halt_i,
    output logic   fetch_en_o,
    output logic   retire_o,
    output logic   stall_o,
    output logic   bogus_o,
    output logic   cnt_clr_o,
    output logic   rnd_clr_o,
    output logic   prng_step_o
);
    logic in_exec, live, bad_word, running;

    // Strobe decode for the current cycle.
    always_comb begin
        in_exec     = (phase_i == PH_EXEC);
        live        = in_exec && have_insn_i;
        bad_word    = !fetch_ok_i || imem_void_i;
        running     = (phase_i != PH_IDLE);
        bogus_o     = live && bad_word;
        retire_o    = live && !bad_word && !busy_i;
        fetch_en_o  = in_exec && (!have_insn_i || (retire_o && !fstall_i && !halt_i));
        stall_o     = running && !retire_o;
        cnt_clr_o   = (phase_i == PH_PREP) || (phase_i == PH_FWAIT);
        rnd_clr_o   = (phase_i == PH_PREP);
        prng_step_o = running && (phase_i != PH_PREP);
    end
endmodule

// File: rtl/run_insn_counter.sv
// Retired-instruction counter: cleared on request, saturating increment.
// Assumes: clear has priority over increment.
module run_insn_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Count retirements, hold at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (clr_i)                      cnt_q <= '0;
        else if (inc_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + CNT_ONE;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/run_ctrl_seq.sv
// Top of the run-phase sequencer: phase FSM, strobe decode, counter.
// Assumes: instruction flags are valid in the cycle they describe.
module run_ctrl_seq
    import run_ctrl_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             seed_ready_i,
    input  logic             fetch_ok_i,
    input  logic             imem_void_i,
    input  logic             busy_i,
    input  logic             fstall_i,
    input  logic             halt_i,
    output logic             fetch_en_o,
    output logic             retire_o,
    output logic             stall_o,
    output logic             fault_o,
    output logic             cnt_clr_o,
    output logic             rnd_req_clr_o,
    output logic             prng_step_o,
    output logic [CNT_W-1:0] insn_cnt_o,
    output logic [2:0]       phase_o
);
    phase_e phase;
    logic   have_insn;
    logic   retire, bogus, cnt_clr;

    run_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .seed_ready_i (seed_ready_i),
        .retire_i     (retire),
        .bogus_i      (bogus),
        .fstall_i     (fstall_i),
        .halt_i       (halt_i),
        .phase_o      (phase),
        .have_insn_o  (have_insn)
    );

    run_issue_logic u_issue (
        .phase_i     (phase),
        .have_insn_i (have_insn),
        .fetch_ok_i  (fetch_ok_i),
        .imem_void_i (imem_void_i),
        .busy_i      (busy_i),
        .fstall_i    (fstall_i),
        .halt_i      (halt_i),
        .fetch_en_o  (fetch_en_o),
        .retire_o    (retire),
        .stall_o     (stall_o),
        .bogus_o     (bogus),
        .cnt_clr_o   (cnt_clr),
        .rnd_clr_o   (rnd_req_clr_o),
        .prng_step_o (prng_step_o)
    );

    run_insn_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (retire),
        .cnt_o (insn_cnt_o)
    );

    assign retire_o  = retire;
    assign fault_o   = bogus;
    assign cnt_clr_o = cnt_clr;
    assign phase_o   = phase;
endmodule

// File: rtl/run_ctrl_seq_chk.sv
// Assertion checker for run_ctrl_seq, attached through bind.
// Assumes: phase codes as in run_ctrl_pkg.
module run_ctrl_seq_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             fstall_i,
    input logic             halt_i,
    input logic             fetch_en_o,
    input logic             retire_o,
    input logic             stall_o,
    input logic             fault_o,
    input logic             prng_step_o,
    input logic [CNT_W-1:0] insn_cnt_o,
    input logic [2:0]       phase_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    AST_RETIRE_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        retire_o |-> phase_o == 3'd3);                                  // R8
    AST_FWAIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 3'd2 |-> !fetch_en_o && insn_cnt_o == '0);           // R4
    AST_PREP_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 3'd1 |-> !prng_step_o);                              // R3
    AST_STALL_XOR_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !(retire_o && stall_o));                                        // R13
    AST_BUBBLE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        retire_o && fstall_i && !halt_i |=> !retire_o && stall_o && fetch_en_o); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        retire_o && insn_cnt_o != CNT_MAX |=> insn_cnt_o == $past(insn_cnt_o) + CNT_ONE); // R8
    AST_FAULT_WIND: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> phase_o == 3'd4);                                   // R11
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 3'd5 |=> phase_o == 3'd5 && stall_o);                // R12
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 3'd0 && start_i |=> phase_o == 3'd1);                // R2
endmodule

bind run_ctrl_seq run_ctrl_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .fstall_i    (fstall_i),
    .halt_i      (halt_i),
    .fetch_en_o  (fetch_en_o),
    .retire_o    (retire_o),
    .stall_o     (stall_o),
    .fault_o     (fault_o),
    .prng_step_o (prng_step_o),
    .insn_cnt_o  (insn_cnt_o),
    .phase_o     (phase_o)
);

// File: tb/tb_run_ctrl_seq.sv
// Directed bench for run_ctrl_seq: one task per scenario.
module tb_run_ctrl_seq;
    localparam int CNT_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, seed_ready_i = 1'b0, fetch_ok_i = 1'b1, imem_void_i = 1'b0;
    logic busy_i = 1'b0, fstall_i = 1'b0, halt_i = 1'b0;
    logic fetch_en_o, retire_o, stall_o, fault_o, cnt_clr_o, rnd_req_clr_o, prng_step_o;
    logic [CNT_W-1:0] insn_cnt_o;
    logic [2:0] phase_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    run_ctrl_seq #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_ready_i(seed_ready_i),
        .fetch_ok_i(fetch_ok_i), .imem_void_i(imem_void_i), .busy_i(busy_i),
        .fstall_i(fstall_i), .halt_i(halt_i), .fetch_en_o(fetch_en_o),
        .retire_o(retire_o), .stall_o(stall_o), .fault_o(fault_o),
        .cnt_clr_o(cnt_clr_o), .rnd_req_clr_o(rnd_req_clr_o),
        .prng_step_o(prng_step_o), .insn_cnt_o(insn_cnt_o), .phase_o(phase_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Advance to the next falling edge, then let outputs settle.
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_inputs();
        start_i = 0; seed_ready_i = 0; fetch_ok_i = 1; imem_void_i = 0;
        busy_i = 0; fstall_i = 0; halt_i = 0;
    endtask

    task automatic do_reset();
        clear_inputs();
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        #1;
        chk("R1", "phase", phase_o, 0);
        chk("R1", "count", insn_cnt_o, 0);
        chk("R1", "strobes", {fetch_en_o, retire_o, stall_o, fault_o, prng_step_o}, 0);
    endtask

    // Idle -> prepare -> fetch-wait -> execute with an instruction on hand.
    task automatic t_bringup(input bit deep);
        start_i = 1; tick(); start_i = 0;
        if (deep) begin
            chk("R2", "prepare entered", phase_o, 1);
            chk("R3", "rnd clr", rnd_req_clr_o, 1);
            chk("R3", "cnt clr", cnt_clr_o, 1);
            chk("R3", "no step", prng_step_o, 0);
            chk("R13", "prep stall", stall_o, 1);
        end
        tick();
        if (deep) chk("R3", "waits for seed", phase_o, 1);
        seed_ready_i = 1; tick(); seed_ready_i = 0;
        chk("R4", "fetch-wait", phase_o, 2);
        chk("R4", "no fetch", fetch_en_o, 0);
        chk("R4", "count zero", insn_cnt_o, 0);
        if (deep) chk("R5", "step in fwait", prng_step_o, 1);
        tick();
        chk("R4", "execute after one", phase_o, 3);
        if (deep) begin
            chk("R6", "first fetch", fetch_en_o, 1);
            chk("R6", "first stall", stall_o, 1);
            chk("R6", "no retire", retire_o, 0);
            chk("R5", "step in exec", prng_step_o, 1);
        end
        tick();
    endtask

    task automatic t_normal_run();
        busy_i = 1; start_i = 1; #1;
        chk("R7", "busy stall", stall_o, 1);
        chk("R7", "busy no retire", retire_o, 0);
        chk("R7", "busy no fetch", fetch_en_o, 0);
        tick(); start_i = 0;
        chk("R2", "start ignored", phase_o, 3);
        busy_i = 0; #1;
        chk("R8", "retire", retire_o, 1);
        chk("R13", "no stall on retire", stall_o, 0);
        chk("R8", "fetch on retire", fetch_en_o, 1);
        tick();
        chk("R8", "count one", insn_cnt_o, 1);
        fstall_i = 1; #1;
        chk("R9", "retire flagged", retire_o, 1);
        chk("R9", "no fetch flagged", fetch_en_o, 0);
        tick(); fstall_i = 0; #1;
        chk("R9", "bubble stall", stall_o, 1);
        chk("R9", "bubble no retire", retire_o, 0);
        chk("R9", "bubble fetch", fetch_en_o, 1);
        tick();
        chk("R9", "retire after bubble", retire_o, 1);
        halt_i = 1; #1;
        chk("R10", "halt no fetch", fetch_en_o, 0);
        tick(); halt_i = 0; #1;
        chk("R10", "wind-down", phase_o, 4);
        chk("R5", "step in wind", prng_step_o, 1);
        chk("R8", "count three", insn_cnt_o, 3);
        tick();
        chk("R10", "idle again", phase_o, 0);
        chk("R10", "count held", insn_cnt_o, 3);
        chk("R5", "no step idle", prng_step_o, 0);
        chk("R13", "no stall idle", stall_o, 0);
    endtask

    task automatic t_saturate();
        t_bringup(0);
        for (int i = 0; i < 9; i++) tick();
        chk("R8", "count saturates", insn_cnt_o, 7);
        halt_i = 1; tick(); halt_i = 0; tick();
        chk("R10", "idle after sat", phase_o, 0);
    endtask

    task automatic t_fault_busy();
        t_bringup(0);
        busy_i = 1; #1;
        chk("R7", "busy before fault", stall_o, 1);
        tick();
        fetch_ok_i = 0; #1;
        chk("R11", "fault while busy", fault_o, 1);
        chk("R11", "no retire on fault", retire_o, 0);
        tick(); fetch_ok_i = 1; busy_i = 0; #1;
        chk("R11", "wind after fault", phase_o, 4);
        chk("R11", "not counted", insn_cnt_o, 0);
        tick();
        chk("R11", "lock", phase_o, 5);
        start_i = 1; tick(); start_i = 0;
        chk("R12", "lock holds", phase_o, 5);
        chk("R12", "lock stalls", stall_o, 1);
        chk("R5", "step in lock", prng_step_o, 1);
    endtask

    task automatic t_fault_void();
        t_bringup(0);
        imem_void_i = 1; #1;
        chk("R11", "void fault", fault_o, 1);
        chk("R11", "void no retire", retire_o, 0);
        tick(); imem_void_i = 0; tick();
        chk("R11", "void lock", phase_o, 5);
        chk("R11", "void not counted", insn_cnt_o, 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL R1 watchdog: actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_bringup(1);
        t_normal_run();
        t_saturate();
        t_fault_busy();
        do_reset();
        t_fault_void();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule